// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single atomic-access reservation of one processor core. A load-reserve pulse records a valid reservation together with the granule-aligned address it covers. A later store-conditional pulse is answered one cycle later with a pass or fail result, and the reservation is gone from that same cycle whether the store passed or not. Between the two, the reservation can be lost to outside activity. Any of eight interrupt classes being taken clears it. A bus snoop of a modifying type that hits the reserved granule clears it. A cache-management operation from another core that targets the granule clears it. For a remote block-allocate, a qualifier input says whether the operation newly establishes or modifies the block, and the reservation is cleared only in that case.

The control is a two-state machine. In `IDLE` no reservation is held. In `HELD` one reservation is held. The transitions are:

- `LOAD`: IDLE or HELD to HELD, on a load-reserve. This also replaces the address when the state is already HELD.
- `CONSUME`: HELD to IDLE, on a store-conditional.
- `KILL`: HELD to IDLE, on any clearing event.
- `STAY`: no change, in every other case.

A load-reserve outranks a store-conditional or a clearing event in the same cycle. A clearing event outranks a store-conditional, so the store fails.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous active-low reset drives `rsv_valid_o`, `rsv_addr_o`, `sc_done_o` and `sc_pass_o` to 0. A reset taken while a reservation is held also clears it.
- R2: A load-reserve sets `rsv_valid_o` on the next cycle, with `rsv_addr_o` equal to the load address with bits [4:0] forced to zero. The granule is 32 bytes. A later load-reserve replaces both the flag and the address. While no reservation is held, `rsv_addr_o` reads 0.
- R3: A store-conditional raises `sc_done_o` for exactly one cycle, one cycle after the request. In that cycle `sc_pass_o` is 1 only if a reservation was held and bits [31:5] of the store address equal those of the reserved address. From that cycle on, the reservation is invalid whatever the result.
- R4: When any bit of `irq_taken_i` is 1, the reservation is cleared on the next cycle. The bits are: 0 external, 1 performance monitor, 2 critical input, 3 machine check, 4 fixed-interval timer, 5 decrementer, 6 unconditional debug, 7 watchdog.
- R5: A snoop whose granule matches the reservation clears it when `snp_kind_i` is one of the following: 1 read-with-intent-to-modify, 2 read-claim, 3 write, 4 flush, 5 kill, 6 data-cache kill.
- R6: A snoop with `snp_kind_i` equal to 0 (plain read) or 7 (clean) has no effect, and neither does a snoop whose granule misses.
- R7: A remote operation whose granule matches clears the reservation when `rmt_op_i` is 0 (touch-for-store) or 1 (flush). Op 3 (touch-for-load) and any remote operation whose granule misses have no effect.
- R8: A remote operation with `rmt_op_i` equal to 2 (block-allocate) that matches the granule clears the reservation only when `rmt_alloc_mod_i` is 1. Otherwise the reservation is kept.
- R9: If a store-conditional and a clearing event arrive in the same cycle, the store-conditional fails.
- R10: If a load-reserve and a clearing event arrive in the same cycle, the new reservation is established.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_rsv_i | input | 1 | Load-reserve request pulse |
| ld_addr_i | input | 32 | Load-reserve address |
| st_cond_i | input | 1 | Store-conditional request pulse |
| st_addr_i | input | 32 | Store-conditional address |
| irq_taken_i | input | 8 | One bit per interrupt class taken this cycle |
| snp_vld_i | input | 1 | Snoop present |
| snp_kind_i | input | 3 | Snoop type code |
| snp_addr_i | input | 32 | Snoop address |
| rmt_vld_i | input | 1 | Remote cache operation present |
| rmt_op_i | input | 2 | Remote operation code |
| rmt_addr_i | input | 32 | Remote operation address |
| rmt_alloc_mod_i | input | 1 | Remote allocate establishes or modifies the block |
| rsv_valid_o | output | 1 | Reservation held |
| rsv_addr_o | output | 32 | Granule-aligned reserved address |
| sc_done_o | output | 1 | Store-conditional result strobe |
| sc_pass_o | output | 1 | Store-conditional succeeded |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a granule of 2^5 bytes and eight interrupt classes. With a 32-byte granule, addresses that differ only in bits [4:0] test the granule match, and addresses that differ higher up test the miss case. Eight interrupt lines let each class be pulsed on its own, and the full 3-bit snoop code and 2-bit remote code let every type be driven, including the ones that must be ignored.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_HELD = 1'b1} resv_state_e;

    typedef enum logic [2:0] {
        SNP_READ     = 3'd0,
        SNP_RD_OWN   = 3'd1,
        SNP_RD_CLAIM = 3'd2,
        SNP_WRITE    = 3'd3,
        SNP_FLUSH    = 3'd4,
        SNP_KILL     = 3'd5,
        SNP_DKILL    = 3'd6,
        SNP_CLEAN    = 3'd7
    } snoop_kind_e;

    typedef enum logic [1:0] {
        RMT_TOUCH_ST = 2'd0,
        RMT_FLUSH    = 2'd1,
        RMT_ALLOC    = 2'd2,
        RMT_TOUCH_LD = 2'd3
    } remote_op_e;

    localparam int NUM_IRQ_CLASSES = 8;
endpackage

// File: rtl/resv_granule_match.sv
module resv_granule_match #(
    parameter int AW        = 32,
    parameter int GRAN_LOG2 = 5
) (
    input  logic [AW-1:0] probe_i,
    input  logic [AW-1:0] held_i,
    output logic          hit_o
);
    localparam logic [AW-1:0] GRAN_MASK = {{(AW-GRAN_LOG2){1'b1}}, {GRAN_LOG2{1'b0}}};

    always_comb hit_o = (((probe_i ^ held_i) & GRAN_MASK) == '0);
endmodule

// File: rtl/resv_kill_decode.sv
module resv_kill_decode
    import resv_pkg::*;
#(
    parameter int NIRQ = NUM_IRQ_CLASSES
) (
    input  logic [NIRQ-1:0] irq_taken_i,
    input  logic            snp_vld_i,
    input  logic [2:0]      snp_kind_i,
    input  logic            snp_hit_i,
    input  logic            rmt_vld_i,
    input  logic [1:0]      rmt_op_i,
    input  logic            rmt_hit_i,
    input  logic            rmt_alloc_mod_i,
    output logic            kill_o
);
    logic snp_kills;
    logic rmt_kills;

    always_comb begin
        unique case (snoop_kind_e'(snp_kind_i))
            SNP_RD_OWN, SNP_RD_CLAIM, SNP_WRITE,
            SNP_FLUSH, SNP_KILL, SNP_DKILL: snp_kills = 1'b1;
            SNP_READ, SNP_CLEAN:            snp_kills = 1'b0;
            default:                        snp_kills = 1'b0;
        endcase
    end

    always_comb begin
        unique case (remote_op_e'(rmt_op_i))
            RMT_TOUCH_ST, RMT_FLUSH: rmt_kills = 1'b1;
            RMT_ALLOC:               rmt_kills = rmt_alloc_mod_i;
            RMT_TOUCH_LD:            rmt_kills = 1'b0;
            default:                 rmt_kills = 1'b0;
        endcase
    end

    always_comb kill_o = (|irq_taken_i)
                       | (snp_vld_i & snp_hit_i & snp_kills)
                       | (rmt_vld_i & rmt_hit_i & rmt_kills);
endmodule

// File: rtl/resv_fsm.sv
module resv_fsm
    import resv_pkg::*;
#(
    parameter int AW        = 32,
    parameter int GRAN_LOG2 = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_rsv_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic          st_cond_i,
    input  logic          st_hit_i,
    input  logic          kill_i,
    output logic          rsv_valid_o,
    output logic [AW-1:0] rsv_addr_o,
    output logic          sc_done_o,
    output logic          sc_pass_o
);
    localparam logic [AW-1:0] GRAN_MASK = {{(AW-GRAN_LOG2){1'b1}}, {GRAN_LOG2{1'b0}}};

    resv_state_e   state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_rsv_i) begin
                    state_d = ST_HELD;
                    addr_d  = ld_addr_i & GRAN_MASK;
                end
            end
            ST_HELD: begin
                if (ld_rsv_i) begin
                    addr_d = ld_addr_i & GRAN_MASK;
                end else if (kill_i || st_cond_i) begin
                    state_d = ST_IDLE;
                    addr_d  = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                addr_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done_o <= 1'b0;
            sc_pass_o <= 1'b0;
        end else begin
            sc_done_o <= st_cond_i;
            sc_pass_o <= st_cond_i && (state_q == ST_HELD) && st_hit_i && !kill_i;
        end
    end

    always_comb rsv_valid_o = (state_q == ST_HELD);
    always_comb rsv_addr_o  = addr_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsv_valid_o && !sc_done_o && rsv_addr_o == '0));

    // R2
    load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rsv_i |=> (rsv_valid_o && rsv_addr_o == ($past(ld_addr_i) & GRAN_MASK)));

    // R3
    sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cond_i && !ld_rsv_i) |=> !rsv_valid_o);

    // R3
    sc_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done_o |-> $past(st_cond_i));

    // R3
    sc_pass_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done_o && sc_pass_o) |-> $past(rsv_valid_o));

    // R9
    kill_beats_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cond_i && kill_i) |=> !sc_pass_o);

    // R10
    load_beats_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rsv_i && kill_i) |=> rsv_valid_o);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int AW        = 32,
    parameter int GRAN_LOG2 = 5,
    parameter int NIRQ      = NUM_IRQ_CLASSES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_rsv_i,
    input  logic [AW-1:0]   ld_addr_i,
    input  logic            st_cond_i,
    input  logic [AW-1:0]   st_addr_i,
    input  logic [NIRQ-1:0] irq_taken_i,
    input  logic            snp_vld_i,
    input  logic [2:0]      snp_kind_i,
    input  logic [AW-1:0]   snp_addr_i,
    input  logic            rmt_vld_i,
    input  logic [1:0]      rmt_op_i,
    input  logic [AW-1:0]   rmt_addr_i,
    input  logic            rmt_alloc_mod_i,
    output logic            rsv_valid_o,
    output logic [AW-1:0]   rsv_addr_o,
    output logic            sc_done_o,
    output logic            sc_pass_o
);
    localparam int NPROBE = 3;

    logic [AW-1:0] probe_addr [NPROBE];
    logic [NPROBE-1:0] probe_hit;
    logic kill;
    logic [AW-1:0] held_addr;

    always_comb begin
        probe_addr[0] = st_addr_i;
        probe_addr[1] = snp_addr_i;
        probe_addr[2] = rmt_addr_i;
    end

    for (genvar p = 0; p < NPROBE; p++) begin : g_match
        resv_granule_match #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_match (
            .probe_i (probe_addr[p]),
            .held_i  (held_addr),
            .hit_o   (probe_hit[p])
        );
    end

    resv_kill_decode #(.NIRQ(NIRQ)) u_kill (
        .irq_taken_i     (irq_taken_i),
        .snp_vld_i       (snp_vld_i),
        .snp_kind_i      (snp_kind_i),
        .snp_hit_i       (probe_hit[1]),
        .rmt_vld_i       (rmt_vld_i),
        .rmt_op_i        (rmt_op_i),
        .rmt_hit_i       (probe_hit[2]),
        .rmt_alloc_mod_i (rmt_alloc_mod_i),
        .kill_o          (kill)
    );

    resv_fsm #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_rsv_i    (ld_rsv_i),
        .ld_addr_i   (ld_addr_i),
        .st_cond_i   (st_cond_i),
        .st_hit_i    (probe_hit[0]),
        .kill_i      (kill),
        .rsv_valid_o (rsv_valid_o),
        .rsv_addr_o  (held_addr),
        .sc_done_o   (sc_done_o),
        .sc_pass_o   (sc_pass_o)
    );

    always_comb rsv_addr_o = held_addr;

    // R4
    irq_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_taken_i) && !ld_rsv_i) |=> !rsv_valid_o);

    // R8
    alloc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid_o && rmt_vld_i && rmt_op_i == 2'd2 && !rmt_alloc_mod_i
         && !snp_vld_i && !st_cond_i && irq_taken_i == '0)
        |=> (rsv_valid_o && $stable(rsv_addr_o)));
endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
    localparam int AW = 32;
    localparam int NIRQ = 8;
    localparam logic [31:0] A = 32'h1000_0040;
    localparam logic [31:0] B = 32'h2000_0080;

    localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_IRQ = 3'd2, K_SNP = 3'd3,
                           K_RMT = 3'd4, K_STIRQ = 3'd5, K_LDIRQ = 3'd6;

    typedef struct packed {
        logic [3:0]  rq;
        logic [2:0]  kind;
        logic [31:0] addr;
        logic [2:0]  sel;
        logic        qual;
        logic        ev;
        logic        ep;
        logic [31:0] ea;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  K_LD,    A + 32'h4,  3'd0, 1'b0, 1'b1, 1'b0, A},  // R2
        '{4'd3,  K_ST,    A + 32'h8,  3'd0, 1'b0, 1'b0, 1'b1, 32'h0}, // R3 pass
        '{4'd3,  K_ST,    A,          3'd0, 1'b0, 1'b0, 1'b0, 32'h0}, // R3 no resv
        '{4'd2,  K_LD,    A,          3'd0, 1'b0, 1'b1, 1'b0, A},
        '{4'd2,  K_LD,    B + 32'h1c, 3'd0, 1'b0, 1'b1, 1'b0, B},  // R2 replace
        '{4'd3,  K_ST,    A,          3'd0, 1'b0, 1'b0, 1'b0, 32'h0}, // R3 miss
        '{4'd2,  K_LD,    A,          3'd0, 1'b0, 1'b1, 1'b0, A},
        '{4'd4,  K_IRQ,   A,          3'd5, 1'b0, 1'b0, 1'b0, 32'h0}, // R4
        '{4'd2,  K_LD,    A,          3'd0, 1'b0, 1'b1, 1'b0, A},
        '{4'd6,  K_SNP,   A,          3'd0, 1'b0, 1'b1, 1'b0, A},  // R6 read
        '{4'd6,  K_SNP,   A,          3'd7, 1'b0, 1'b1, 1'b0, A},  // R6 clean
        '{4'd6,  K_SNP,   B,          3'd3, 1'b0, 1'b1, 1'b0, A},  // R6 miss
        '{4'd5,  K_SNP,   A + 32'h10, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0}, // R5
        '{4'd2,  K_LD,    A,          3'd0, 1'b0, 1'b1, 1'b0, A},
        '{4'd7,  K_RMT,   A,          3'd3, 1'b0, 1'b1, 1'b0, A},  // R7 touch-load
        '{4'd8,  K_RMT,   A,          3'd2, 1'b0, 1'b1, 1'b0, A},  // R8 kept
        '{4'd8,  K_RMT,   A,          3'd2, 1'b1, 1'b0, 1'b0, 32'h0}, // R8 cleared
        '{4'd2,  K_LD,    A,          3'd0, 1'b0, 1'b1, 1'b0, A},
        '{4'd7,  K_RMT,   B,          3'd0, 1'b0, 1'b1, 1'b0, A},  // R7 miss
        '{4'd7,  K_RMT,   A,          3'd1, 1'b0, 1'b0, 1'b0, 32'h0}, // R7 flush
        '{4'd2,  K_LD,    A,          3'd0, 1'b0, 1'b1, 1'b0, A},
        '{4'd9,  K_STIRQ, A,          3'd0, 1'b0, 1'b0, 1'b0, 32'h0}, // R9
        '{4'd10, K_LDIRQ, B,          3'd7, 1'b0, 1'b1, 1'b0, B}   // R10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_rsv_i = 1'b0, st_cond_i = 1'b0, snp_vld_i = 1'b0, rmt_vld_i = 1'b0, rmt_alloc_mod_i = 1'b0;
    logic [AW-1:0] ld_addr_i = '0, st_addr_i = '0, snp_addr_i = '0, rmt_addr_i = '0;
    logic [NIRQ-1:0] irq_taken_i = '0;
    logic [2:0] snp_kind_i = '0;
    logic [1:0] rmt_op_i = '0;
    logic rsv_valid_o, sc_done_o, sc_pass_o;
    logic [AW-1:0] rsv_addr_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    resv_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .ld_rsv_i(ld_rsv_i), .ld_addr_i(ld_addr_i),
        .st_cond_i(st_cond_i), .st_addr_i(st_addr_i),
        .irq_taken_i(irq_taken_i),
        .snp_vld_i(snp_vld_i), .snp_kind_i(snp_kind_i), .snp_addr_i(snp_addr_i),
        .rmt_vld_i(rmt_vld_i), .rmt_op_i(rmt_op_i), .rmt_addr_i(rmt_addr_i),
        .rmt_alloc_mod_i(rmt_alloc_mod_i),
        .rsv_valid_o(rsv_valid_o), .rsv_addr_o(rsv_addr_o),
        .sc_done_o(sc_done_o), .sc_pass_o(sc_pass_o)
    );

    task automatic check(input string tag, input logic v, input logic [31:0] a,
                         input logic d, input logic p);
        checks++;
        if (rsv_valid_o !== v || rsv_addr_o !== a || sc_done_o !== d || (d && sc_pass_o !== p)) begin
            fails++;
            $display("FAIL %s: got valid=%0b addr=%h done=%0b pass=%0b, want valid=%0b addr=%h done=%0b pass=%0b",
                     tag, rsv_valid_o, rsv_addr_o, sc_done_o, sc_pass_o, v, a, d, p);
        end
    endtask

    task automatic apply(input logic [2:0] kind, input logic [31:0] addr,
                         input logic [2:0] sel, input logic qual);
        @(negedge clk);
        case (kind)
            K_LD:    begin ld_rsv_i = 1'b1; ld_addr_i = addr; end
            K_ST:    begin st_cond_i = 1'b1; st_addr_i = addr; end
            K_IRQ:   irq_taken_i[sel] = 1'b1;
            K_SNP:   begin snp_vld_i = 1'b1; snp_kind_i = sel; snp_addr_i = addr; end
            K_RMT:   begin rmt_vld_i = 1'b1; rmt_op_i = sel[1:0]; rmt_addr_i = addr; rmt_alloc_mod_i = qual; end
            K_STIRQ: begin st_cond_i = 1'b1; st_addr_i = addr; irq_taken_i[sel] = 1'b1; end
            K_LDIRQ: begin ld_rsv_i = 1'b1; ld_addr_i = addr; irq_taken_i[sel] = 1'b1; end
            default: ;
        endcase
        @(negedge clk);
        ld_rsv_i = 1'b0; st_cond_i = 1'b0; snp_vld_i = 1'b0; rmt_vld_i = 1'b0;
        rmt_alloc_mod_i = 1'b0; irq_taken_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].kind, VEC[i].addr, VEC[i].sel, VEC[i].qual);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].ea,
                  (VEC[i].kind == K_ST || VEC[i].kind == K_STIRQ), VEC[i].ep);
        end

        // R3: result strobe lasts one cycle
        @(negedge clk);
        check("R3 strobe drops", 1'b1, B, 1'b0, 1'b0);

        // R4: every interrupt class clears on its own
        for (int b = 0; b < NIRQ; b++) begin
            apply(K_LD, A, 3'd0, 1'b0);
            apply(K_IRQ, A, 3'(b), 1'b0);
            check($sformatf("R4 irq class %0d", b), 1'b0, 32'h0, 1'b0, 1'b0);
        end

        // R5: every clearing snoop type on a matching granule
        for (int t = 1; t <= 6; t++) begin
            apply(K_LD, A, 3'd0, 1'b0);
            apply(K_SNP, A + 32'h1f, 3'(t), 1'b0);
            check($sformatf("R5 snoop kind %0d", t), 1'b0, 32'h0, 1'b0, 1'b0);
        end

        // R7: touch-for-store clears
        apply(K_LD, B, 3'd0, 1'b0);
        apply(K_RMT, B + 32'h4, 3'd0, 1'b0);
        check("R7 touch-for-store", 1'b0, 32'h0, 1'b0, 1'b0);

        // R3: store in the next granule up fails
        apply(K_LD, A, 3'd0, 1'b0);
        apply(K_ST, A + 32'h20, 3'd0, 1'b0);
        check("R3 adjacent granule", 1'b0, 32'h0, 1'b1, 1'b0);

        // R1: reset while held
        apply(K_LD, A, 3'd0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset while held", 1'b0, 32'h0, 1'b0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: got hang, want completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule